// File: doc/BRIEF.md
# Integer Result and Status Flag Unit

This block computes a 32-bit integer result from two operands and an operation code, then records the status that the instruction asks for. Three per-instruction enables control the recording. The overflow enable records signed overflow. The carry enable records the carry out of the most significant bit. The compare enable writes a signed compare of the result against zero into the top field of a condition register.

The summary overflow flag is sticky. Once an overflow is recorded it stays set until reset, and it is copied into every compare field written later. The flags therefore depend on the history of earlier instructions, not only on the current result.

The result is combinational and is valid in the same cycle as the operands. All status state is registered and changes at the next rising clock edge. The add-with-carry operation reads the registered carry flag as its extra addend.

Top module: `alu_flag_unit`

## Requirements
- R1: `result_o` follows the operands in the same cycle. The `op_i` encoding is: 0 add, 1 add with carry, 2 AND, 3 OR, 4 XOR, 5 bitwise NOT of `a_i`, and 6 or 7 pass `a_i` through unchanged.
- R2: With `ca_en_i` high on op 0 or op 1, `ca_o` holds the unsigned carry out of bit 31 of the sum after the next rising edge.
- R3: With `oe_i` high and a signed 32-bit overflow, both `ov_o` and `so_o` are 1 after the next edge.
- R4: With `oe_i` high and no overflow, `ov_o` is cleared after the next edge and `so_o` keeps its previous value.
- R5: `so_o` is sticky and only reset clears it. With `oe_i` low, neither `ov_o` nor `so_o` changes.
- R6: With `ca_en_i` low, `ca_o` keeps its value.
- R7: Op 1 adds the current `ca_o` (0 or 1) as a third addend, both to the result and to the carry and overflow computation.
- R8: Ops 2 to 7 produce no carry and no overflow. With the enables set, they clear `ca_o` and `ov_o`.
- R9: With `rc_i` high, `cr_o[31:28]` becomes {LT, GT, EQ, SO} after the next edge. LT, GT and EQ form a one-hot signed compare of the result with zero. SO is the value of `so_o` after this instruction's own overflow update.
- R10: With `rc_i` low, `cr_o` keeps its value. `cr_o[27:0]` (fields 1 to 7, four bits each, with field n at bits 31-4n down to 28-4n) is never written and stays zero.
- R11: A synchronous active-high `rst_i` clears `so_o`, `ov_o`, `ca_o` and `cr_o` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| oe_i | input | 1 | Record overflow for this instruction |
| ca_en_i | input | 1 | Record carry for this instruction |
| rc_i | input | 1 | Write compare field 0 for this instruction |
| result_o | output | 32 | Combinational result |
| so_o | output | 1 | Sticky summary overflow flag |
| ov_o | output | 1 | Overflow flag |
| ca_o | output | 1 | Carry flag |
| cr_o | output | 32 | Condition register |

## Verification
`result_o` is due in the same cycle as its operands, so the bench drives each stimulus on a falling edge and checks the result one nanosecond later, before any rising edge. The flags and `cr_o` are due one rising edge later, so the bench checks them one nanosecond after that edge, while the enables are still held. Because op 1 reads the registered carry, the bench's own model advances only at that same edge, which keeps expected carry-in values aligned with the design across back-to-back instructions.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_NOT  = 3'd5,
    OP_PAS6 = 3'd6,
    OP_PAS7 = 3'd7
  } alu_op_e;

  localparam int CR_FIELD_W = 4;

  // compare code from MSB: less, greater, equal, summary overflow
  function automatic logic [CR_FIELD_W-1:0] cr_code(input logic neg,
                                                    input logic zero,
                                                    input logic so);
    cr_code = {neg, (!neg && !zero), zero, so};
  endfunction

endpackage

// File: rtl/alu_flag_datapath.sv
module alu_flag_datapath
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ca_flag_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_evt_o,
  output logic             ovf_evt_o,
  output logic             neg_o,
  output logic             zero_o
);

  localparam int SW = WIDTH + 1;

  function automatic logic [SW-1:0] wide_add(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] y,
                                             input logic cin);
    wide_add = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  endfunction

  function automatic logic signed_ovf(input logic xs, input logic ys,
                                      input logic rs);
    signed_ovf = (xs == ys) && (rs != xs);
  endfunction

  alu_op_e         op;
  logic [SW-1:0]   sum;
  logic            arith;

  assign op = alu_op_e'(op_i);

  always_comb begin
    arith = (op == OP_ADD) || (op == OP_ADDC);
    sum   = wide_add(a_i, b_i, (op == OP_ADDC) ? ca_flag_i : 1'b0);
    case (op)
      OP_ADD, OP_ADDC: result_o = sum[WIDTH-1:0];
      OP_AND:          result_o = a_i & b_i;
      OP_OR:           result_o = a_i | b_i;
      OP_XOR:          result_o = a_i ^ b_i;
      OP_NOT:          result_o = ~a_i;
      default:         result_o = a_i;
    endcase
    carry_evt_o = arith && sum[WIDTH];
    ovf_evt_o   = arith && signed_ovf(a_i[WIDTH-1], b_i[WIDTH-1], sum[WIDTH-1]);
    neg_o       = result_o[WIDTH-1];
    zero_o      = (result_o == '0);
  end

endmodule

// File: rtl/alu_flag_xer.sv
module alu_flag_xer (
  input  logic clk_i,
  input  logic rst_i,
  input  logic oe_i,
  input  logic ca_en_i,
  input  logic ovf_evt_i,
  input  logic carry_evt_i,
  output logic so_o,
  output logic ov_o,
  output logic ca_o,
  output logic so_next_o
);

  logic so_q, ov_q, ca_q;

  assign so_next_o = so_q | (oe_i & ovf_evt_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      so_q <= 1'b0;
      ov_q <= 1'b0;
      ca_q <= 1'b0;
    end else begin
      if (oe_i) begin
        ov_q <= ovf_evt_i;
        so_q <= so_next_o;
      end
      if (ca_en_i) ca_q <= carry_evt_i;
    end
  end

  assign so_o = so_q;
  assign ov_o = ov_q;
  assign ca_o = ca_q;

endmodule

// File: rtl/alu_flag_cr.sv
module alu_flag_cr
  import alu_flag_pkg::*;
#(
  parameter int NFIELD = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic                           wr_i,
  input  logic [CR_FIELD_W-1:0]          code_i,
  output logic [NFIELD*CR_FIELD_W-1:0]   cr_o
);

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    localparam int LSB = (NFIELD - 1 - g) * CR_FIELD_W;
    logic [CR_FIELD_W-1:0] fld_q;
    logic                  we;
    assign we = (g == 0) ? wr_i : 1'b0;
    always_ff @(posedge clk_i) begin
      if (rst_i)   fld_q <= '0;
      else if (we) fld_q <= code_i;
    end
    assign cr_o[LSB +: CR_FIELD_W] = fld_q;
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int NFIELD = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_i,
  input  logic [2:0]                   op_i,
  input  logic [WIDTH-1:0]             a_i,
  input  logic [WIDTH-1:0]             b_i,
  input  logic                         oe_i,
  input  logic                         ca_en_i,
  input  logic                         rc_i,
  output logic [WIDTH-1:0]             result_o,
  output logic                         so_o,
  output logic                         ov_o,
  output logic                         ca_o,
  output logic [NFIELD*CR_FIELD_W-1:0] cr_o
);

  localparam int CRW = NFIELD * CR_FIELD_W;

  logic                  carry_evt, ovf_evt, res_neg, res_zero, so_next;
  logic [CR_FIELD_W-1:0] cmp_code;

  alu_flag_datapath #(.WIDTH(WIDTH)) u_dp (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .ca_flag_i(ca_o),
    .result_o(result_o), .carry_evt_o(carry_evt), .ovf_evt_o(ovf_evt),
    .neg_o(res_neg), .zero_o(res_zero)
  );

  alu_flag_xer u_xer (
    .clk_i(clk_i), .rst_i(rst_i), .oe_i(oe_i), .ca_en_i(ca_en_i),
    .ovf_evt_i(ovf_evt), .carry_evt_i(carry_evt),
    .so_o(so_o), .ov_o(ov_o), .ca_o(ca_o), .so_next_o(so_next)
  );

  assign cmp_code = cr_code(res_neg, res_zero, so_next);

  alu_flag_cr #(.NFIELD(NFIELD)) u_cr (
    .clk_i(clk_i), .rst_i(rst_i), .wr_i(rc_i), .code_i(cmp_code), .cr_o(cr_o)
  );

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int CRW = 32
) (
  input logic           clk_i,
  input logic           rst_i,
  input logic [2:0]     op_i,
  input logic           oe_i,
  input logic           ca_en_i,
  input logic           rc_i,
  input logic           ovf_evt,
  input logic           carry_evt,
  input logic           so_o,
  input logic           ov_o,
  input logic           ca_o,
  input logic [CRW-1:0] cr_o
);

  assert_ov_sets_so_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (oe_i && ovf_evt) |=> (ov_o && so_o));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (oe_i && !ovf_evt) |=> (!ov_o && (so_o == $past(so_o))));

  assert_so_sticky_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    so_o |=> so_o);

  assert_oe_off_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !oe_i |=> ($stable(ov_o) && $stable(so_o)));

  assert_ca_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !ca_en_i |=> $stable(ca_o));

  assert_logic_flags_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i >= 3'd2) |-> (!carry_evt && !ovf_evt));

  assert_cr_code_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    rc_i |=> (($countones(cr_o[CRW-1:CRW-3]) == 1) && (cr_o[CRW-4] == so_o)));

  assert_cr_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !rc_i |=> $stable(cr_o));

  assert_cr_upper_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    cr_o[CRW-5:0] == '0);

  assert_reset_R11: assert property (@(posedge clk_i)
    rst_i |=> (!so_o && !ov_o && !ca_o && (cr_o == '0)));

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.CRW(CRW)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .op_i(op_i), .oe_i(oe_i), .ca_en_i(ca_en_i),
  .rc_i(rc_i), .ovf_evt(ovf_evt), .carry_evt(carry_evt), .so_o(so_o),
  .ov_o(ov_o), .ca_o(ca_o), .cr_o(cr_o)
);

// File: tb/alu_flag_unit_tb.sv
`timescale 1ns/1ps
module alu_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op;
  logic [31:0] a, b;
  logic        oe, cae, rc;
  logic [31:0] res;
  logic        so, ov, ca;
  logic [31:0] cr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // model state
  logic        m_so, m_ov, m_ca;
  logic [31:0] m_cr;

  always #5 clk = ~clk;

  alu_flag_unit u_dut (
    .clk_i(clk), .rst_i(rst), .op_i(op), .a_i(a), .b_i(b), .oe_i(oe),
    .ca_en_i(cae), .rc_i(rc), .result_o(res), .so_o(so), .ov_o(ov),
    .ca_o(ca), .cr_o(cr)
  );

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " so"}, {31'd0, so}, {31'd0, m_so});
    check({req, " ov"}, {31'd0, ov}, {31'd0, m_ov});
    check({req, " ca"}, {31'd0, ca}, {31'd0, m_ca});
    check({req, " cr"}, cr, m_cr);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; oe = 0; cae = 0; rc = 0; op = 0; a = 0; b = 0;
    @(posedge clk); #1;
    m_so = 0; m_ov = 0; m_ca = 0; m_cr = '0;
    check_state("R11 reset");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [31:0] x,
                        input logic [31:0] y, input logic e_oe,
                        input logic e_ca, input logic e_rc, input string tag);
    logic [31:0] er;
    logic        cin, cy, vf, nso;
    longint      sx;
    logic [63:0] ux;
    @(negedge clk);
    op = o; a = x; b = y; oe = e_oe; cae = e_ca; rc = e_rc;
    cin = (o == 3'd1) ? m_ca : 1'b0;
    cy = 0; vf = 0;
    case (o)
      3'd0, 3'd1: begin
        ux = {32'd0, x} + {32'd0, y} + {63'd0, cin};
        sx = longint'($signed(x)) + longint'($signed(y)) + longint'(cin);
        er = ux[31:0];
        cy = ux[32];
        vf = (sx > 64'sd2147483647) || (sx < -64'sd2147483648);
      end
      3'd2: er = x & y;
      3'd3: er = x | y;
      3'd4: er = x ^ y;
      3'd5: er = ~x;
      default: er = x;
    endcase
    #1;
    check({tag, " R1 R7 result"}, res, er);
    @(posedge clk); #1;
    if (e_oe) begin
      m_ov = vf;
      if (vf) m_so = 1'b1;
    end
    if (e_ca) m_ca = cy;
    nso = m_so;
    if (e_rc)
      m_cr[31:28] = {$signed(er) < 0, $signed(er) > 0, er == 32'd0, nso};
    check_state({tag, " R2 R3 R4 R5 R6 R8 R9 R10"});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [12];
    vals = '{32'h0, 32'h1, 32'h2, 32'h7FFFFFFF, 32'h80000000, 32'h80000001,
             32'hFFFFFFFF, 32'hFFFFFFFE, 32'h55555555, 32'hAAAAAAAA,
             32'h0000FFFF, 32'h12345678};
    rst = 1'b1; op = 0; a = 0; b = 0; oe = 0; cae = 0; rc = 0;
    do_reset();

    // R3 and R9: signed overflow at 0x7FFFFFFF + 1
    run_op(3'd0, 32'h7FFFFFFF, 32'h1, 1, 1, 1, "R3 max+1");
    check("R3 so set", {31'd0, so}, 32'd1);
    check("R9 cr field", cr[31:28], 4'b1001);
    // R4 and R5: later good ops clear OV but keep SO
    run_op(3'd0, 32'h1, 32'h1, 1, 0, 1, "R4 no ovf");
    check("R4 ov clear", {31'd0, ov}, 32'd0);
    check("R5 so kept", {31'd0, so}, 32'd1);
    run_op(3'd2, 32'hF0, 32'h0F, 1, 1, 1, "R5 logic");
    check("R9 eq with so", cr[31:28], 4'b0011);
    // R2 and R7: 0xFFFFFFFF + 1 carries, then add with carry uses it
    do_reset();
    run_op(3'd0, 32'hFFFFFFFF, 32'h1, 1, 1, 1, "R2 wrap");
    check("R2 carry", {31'd0, ca}, 32'd1);
    check("R9 zero no so", cr[31:28], 4'b0010);
    run_op(3'd1, 32'h5, 32'h6, 0, 0, 0, "R7 addc");
    check("R6 ca held", {31'd0, ca}, 32'd1);
    // R8: logic op with carry enable clears carry
    run_op(3'd4, 32'hFFFFFFFF, 32'h0, 1, 1, 0, "R8 xor");
    check("R8 ca cleared", {31'd0, ca}, 32'd0);

    // near-exhaustive sweep over interesting operands and all op codes
    do_reset();
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int o = 0; o < 8; o++) begin
          int k;
          k = (i * 7 + j * 3 + o) % 8;
          run_op(3'(o), vals[i], vals[j], k[0], k[1], k[2], "sweep");
        end

    // R11: reset after a sweep clears everything
    do_reset();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule